// File: doc/BRIEF.md
# Indirect register access window

This block gives a host a small 32-byte I/O window onto a much larger memory-mapped register file. The window has two 32-bit ports. One is an offset latch, at byte 0, and the other is a data port, at byte 4. The host first writes the target register offset into the latch. It then reads or writes the data port. The block forwards that access to an internal register-bus master port, using the latched value as the register offset.

Before anything is forwarded, the latched value goes through a range decode. A value inside the register range is forwarded. Any other value is refused: a refused read returns zero and a refused write never reaches the register bus. Each refused data-port access is sorted into a diagnostic category. That category is reported on a 2-bit code with a one-cycle valid pulse.

The host port is a simple request/ready handshake. The host holds `h_req` and its address and data until it sees `h_ready` high at a clock edge. Forwarded accesses stall the host until the register bus acknowledges. All other accesses complete in the cycle they are presented.

Top module: `ioreg_window`

## Requirements
- R1: After reset the offset latch holds zero, `h_ready` is high when idle, `rb_req` is low and `err_valid` is low.
- R2: A write to window byte offset 0 stores all 32 bits of `h_wdata` in the latch. A read of offset 0 returns the stored value unchanged.
- R3: A data-port access (offset 4) is forwarded only when the latched value is below 0x1FFFF. It issues exactly one register-bus transaction, with `rb_addr` equal to the latched value and with the host's `h_we` and `h_wdata`.
- R4: During a forwarded access `h_ready` stays low and `rb_req` stays high with a steady `rb_addr` until `rb_ack`. The access completes in the `rb_ack` cycle, and a read returns `rb_rdata` there, so it takes 2 plus the bus wait cycles.
- R5: A latched value in [0x1FFFF, 0x7FFFF) is refused with category code 1 (undefined region).
- R6: A latched value in [0x7FFFF, 0xFFFFF) is refused with category code 2 (flash region).
- R7: A latched value of 0xFFFFF or above is refused with category code 3 (unknown).
- R8: A refused data-port access completes in one cycle and raises no `rb_req`. A refused read returns zero.
- R9: An access at any other aligned offset completes in one cycle and returns zero on read. It changes neither the latch nor the register bus, and it raises no error pulse.
- R10: An access whose two low address bits are not zero is unsupported and is ignored in the same way as in R9, even when it lies inside the latch or data words.
- R11: `err_valid` is high for exactly one cycle, the cycle after a refused access is accepted, with the matching nonzero `err_code`. It is never high for a forwarded or ignored access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request, held until accepted |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | WIN_AW | Host byte offset within the window |
| h_wdata | input | DW | Host write data |
| h_ready | output | 1 | Access accepted at this edge |
| h_rdata | output | DW | Read data, valid with `h_ready` |
| rb_req | output | 1 | Register-bus request, held until `rb_ack` |
| rb_we | output | 1 | Register-bus write strobe |
| rb_addr | output | RB_AW | Register offset on the register bus |
| rb_wdata | output | DW | Register-bus write data |
| rb_ack | input | 1 | Register-bus acknowledge |
| rb_rdata | input | DW | Register-bus read data |
| err_valid | output | 1 | One-cycle pulse for a refused access |
| err_code | output | 2 | Category: 1 undefined, 2 flash, 3 unknown |

## Verification
The bench builds the block with its default parameters: a 5-bit window offset, a 32-bit data path and the three range limits at 0x1FFFF, 0x7FFFF and 0xFFFFF. The window is only 32 bytes, so every byte offset is swept, the misaligned ones included. The latch value is driven onto both sides of each range limit. A bench model of the register bus, with an acknowledge delay of 0 to 3 cycles, shows the stall length and the read return at each latency.

// File: rtl/ioreg_window.sv
`timescale 1ns/1ps
module ioreg_window #(
  parameter int          WIN_AW    = 5,
  parameter int          DW        = 32,
  parameter int          RB_AW     = 17,
  parameter int          OFF_ADDR  = 0,
  parameter int          OFF_DATA  = 4,
  parameter logic [31:0] LIM_REG   = 32'h0001_FFFF,
  parameter logic [31:0] LIM_UNDEF = 32'h0007_FFFF,
  parameter logic [31:0] LIM_FLASH = 32'h000F_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [WIN_AW-1:0] h_addr,
  input  logic [DW-1:0]     h_wdata,
  output logic              h_ready,
  output logic [DW-1:0]     h_rdata,
  output logic              rb_req,
  output logic              rb_we,
  output logic [RB_AW-1:0]  rb_addr,
  output logic [DW-1:0]     rb_wdata,
  input  logic              rb_ack,
  input  logic [DW-1:0]     rb_rdata,
  output logic              err_valid,
  output logic [1:0]        err_code
);
  localparam logic [WIN_AW-1:0] A_OFF = OFF_ADDR[WIN_AW-1:0];
  localparam logic [WIN_AW-1:0] D_OFF = OFF_DATA[WIN_AW-1:0];
  localparam logic [DW-1:0]     L_REG = DW'(LIM_REG);
  localparam logic [DW-1:0]     L_UND = DW'(LIM_UNDEF);
  localparam logic [DW-1:0]     L_FLS = DW'(LIM_FLASH);

  logic [DW-1:0] addr_q;
  logic          busy;
  logic          err_v_q;
  logic [1:0]    err_c_q;

  logic aligned, hit_addr, hit_data, in_reg, fwd_start, refused;
  logic [1:0] cat;

  assign aligned  = (h_addr[1:0] == 2'b00);
  assign hit_addr = aligned && (h_addr == A_OFF);
  assign hit_data = aligned && (h_addr == D_OFF);
  assign in_reg   = (addr_q < L_REG);

  always_comb begin
    if (addr_q < L_UND)      cat = 2'd1;
    else if (addr_q < L_FLS) cat = 2'd2;
    else                     cat = 2'd3;
  end

  assign fwd_start = !busy && h_req && hit_data && in_reg;
  assign refused   = !busy && h_req && hit_data && !in_reg;

  assign h_ready = busy ? rb_ack : !fwd_start;
  assign h_rdata = busy ? rb_rdata : ((h_req && hit_addr) ? addr_q : '0);

  assign rb_req   = busy;
  assign rb_we    = busy && h_we;
  assign rb_addr  = addr_q[RB_AW-1:0];
  assign rb_wdata = h_wdata;

  assign err_valid = err_v_q;
  assign err_code  = err_c_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      busy    <= 1'b0;
      err_v_q <= 1'b0;
      err_c_q <= 2'd0;
    end else begin
      if (fwd_start)          busy <= 1'b1;
      else if (busy && rb_ack) busy <= 1'b0;
      if (!busy && h_req && h_we && hit_addr) addr_q <= h_wdata;
      err_v_q <= refused;
      err_c_q <= refused ? cat : 2'd0;
    end
  end
endmodule

// File: rtl/ioreg_window_chk.sv
`timescale 1ns/1ps
module ioreg_window_chk #(
  parameter int          DW      = 32,
  parameter int          RB_AW   = 17,
  parameter logic [31:0] LIM_REG = 32'h0001_FFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             h_req,
  input logic             h_ready,
  input logic             rb_req,
  input logic             rb_ack,
  input logic [RB_AW-1:0] rb_addr,
  input logic             err_valid,
  input logic [1:0]       err_code,
  input logic [DW-1:0]    addr_q
);
  // R3
  fwd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req |-> (addr_q < DW'(LIM_REG)));
  // R4
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_req && !rb_ack) |-> !h_ready);
  // R4
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_req && !rb_ack) |=> (rb_req && $stable(rb_addr)));
  // R3
  single_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_req && rb_ack) |=> !rb_req);
  // R8
  no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_req && h_req && h_ready) |=> !rb_req);
  // R11
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code != 2'd0));
endmodule

bind ioreg_window ioreg_window_chk #(.DW(DW), .RB_AW(RB_AW), .LIM_REG(LIM_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_ready(h_ready), .rb_req(rb_req),
  .rb_ack(rb_ack), .rb_addr(rb_addr), .err_valid(err_valid), .err_code(err_code),
  .addr_q(addr_q)
);

// File: tb/sim_ioreg_window.sv
`timescale 1ns/1ps
module sim_ioreg_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [4:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready;
  logic [31:0] h_rdata;
  logic        rb_req, rb_we, rb_ack = 1'b0;
  logic [16:0] rb_addr;
  logic [31:0] rb_wdata, rb_rdata = '0;
  logic        err_valid;
  logic [1:0]  err_code;

  int tests = 0, fails = 0;
  int lat = 0, wcnt = 0;
  int rb_cnt = 0;
  logic [16:0] last_addr;
  logic        last_we;
  logic [31:0] last_wdata;

  always #4 clk = ~clk;

  ioreg_window u0 (.*);

  function automatic logic [31:0] f(input logic [16:0] a);
    return {15'd0, a} * 32'h9E37_79B1 + 32'd1;
  endfunction

  function automatic logic [1:0] exp_code(input logic [31:0] v);
    if (v < 32'h1FFFF) return 2'd0;
    if (v < 32'h7FFFF) return 2'd1;
    if (v < 32'hFFFFF) return 2'd2;
    return 2'd3;
  endfunction

  always @(negedge clk) begin
    if (rb_req) begin
      if (wcnt >= lat) begin rb_ack = 1'b1; rb_rdata = f(rb_addr); end
      else wcnt++;
    end else begin
      rb_ack = 1'b0; wcnt = 0; rb_rdata = '0;
    end
  end

  always @(posedge clk) if (rb_req && rb_ack) begin
    rb_cnt++; last_addr = rb_addr; last_we = rb_we; last_wdata = rb_wdata;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [4:0] off, input logic [31:0] wd,
                     output logic [31:0] rd, output int cyc, output logic ev,
                     output logic [1:0] ec, output logic ev2);
    logic rdy;
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = off; h_wdata = wd;
    cyc = 0; rd = 'x;
    for (int g = 0; g < 50; g++) begin
      #1;
      rdy = h_ready;
      if (rdy) rd = h_rdata;
      @(posedge clk);
      cyc++;
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0;
    #1; ev = err_valid; ec = err_code;
    @(negedge clk);
    #1; ev2 = err_valid;
  endtask

  task automatic set_latch(input logic [31:0] v);
    logic [31:0] rd; int c; logic e, e2; logic [1:0] ec;
    acc(1'b1, 5'd0, v, rd, c, e, ec, e2);
  endtask

  logic [31:0] pts [12];

  initial begin
    logic [31:0] rd; int cyc; logic ev, ev2; logic [1:0] ec; int n0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(h_ready === 1'b1 && rb_req === 1'b0 && err_valid === 1'b0, "R1 idle outputs",
        {29'd0, h_ready, rb_req, err_valid}, 32'h4);
    acc(1'b0, 5'd0, 0, rd, cyc, ev, ec, ev2);
    chk(rd === 32'h0, "R1 latch reset", rd, 0);

    for (int i = 0; i < 35; i++) begin
      logic [31:0] v;
      v = (i < 32) ? (32'h1 << i) : ((i == 32) ? 32'hFFFF_FFFF : 32'hA5C3_0F96 ^ i);
      set_latch(v);
      acc(1'b0, 5'd0, 0, rd, cyc, ev, ec, ev2);
      chk(rd === v && cyc == 1, "R2 latch readback", rd, v);
    end

    pts = '{32'h0, 32'h4, 32'h100, 32'h1234, 32'h1FFFC, 32'h1FFFE,
            32'h1FFFF, 32'h40000, 32'h7FFFE, 32'h7FFFF, 32'hFFFFE, 32'hFFFFF};
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int p = 0; p < 13; p++) begin
        logic [31:0] a;
        a = (p < 12) ? pts[p] : 32'hFFFF_FFFF;
        set_latch(a);
        for (int w = 0; w < 2; w++) begin
          logic [31:0] wd;
          wd = 32'hC001_0000 + a + w;
          n0 = rb_cnt;
          acc(w[0], 5'd4, wd, rd, cyc, ev, ec, ev2);
          if (exp_code(a) == 2'd0) begin
            chk(rb_cnt == n0 + 1, "R3 one bus txn", rb_cnt - n0, 1);
            chk(last_addr == a[16:0] && last_we == w[0], "R3 bus addr/we", {15'd0, last_addr}, a);
            if (w == 1) chk(last_wdata === wd, "R3 bus wdata", last_wdata, wd);
            else        chk(rd === f(a[16:0]), "R4 read return", rd, f(a[16:0]));
            chk(cyc == 2 + l, "R4 stall length", cyc, 2 + l);
            chk(!ev && !ev2, "R11 no pulse on forward", {31'd0, ev}, 0);
          end else begin
            chk(rb_cnt == n0 && cyc == 1, "R8 refused no bus, one cycle", rb_cnt - n0, 0);
            if (w == 0) chk(rd === 32'h0, "R8 refused read zero", rd, 0);
            chk(ev && ec == exp_code(a),
                exp_code(a) == 1 ? "R5 undefined code" : (exp_code(a) == 2 ? "R6 flash code" : "R7 unknown code"),
                {30'd0, ec}, {30'd0, exp_code(a)});
            chk(!ev2, "R11 single-cycle pulse", {31'd0, ev2}, 0);
          end
        end
      end
    end

    lat = 0;
    for (int o = 0; o < 32; o++) begin
      if (o == 0 || o == 4) continue;
      for (int w = 0; w < 2; w++) begin
        set_latch(32'h0000_0040);
        n0 = rb_cnt;
        acc(w[0], o[4:0], 32'hDEAD_0000 + o, rd, cyc, ev, ec, ev2);
        if (o[1:0] != 0)
          chk(rb_cnt == n0 && cyc == 1 && !ev && (w == 1 || rd === 0), "R10 misaligned ignored", rd, 0);
        else
          chk(rb_cnt == n0 && cyc == 1 && !ev && (w == 1 || rd === 0), "R9 other offset ignored", rd, 0);
        acc(1'b0, 5'd0, 0, rd, cyc, ev, ec, ev2);
        chk(rd === 32'h40, o[1:0] != 0 ? "R10 latch untouched" : "R9 latch untouched", rd, 32'h40);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule